// File: doc/BRIEF.md
# Scanline Interrupt Snooper

This block sits on the cartridge side of a video processor's memory bus and raises a line-synchronous interrupt. It never sees a horizontal sync. It finds the start of each rendered scanline only by watching which addresses the video processor reads. Every line ends with two back-to-back dummy nametable reads. The first nametable fetch of the next line follows them directly, because the horizontal blanking period holds only sprite pattern fetches and the two leading background tiles were already prefetched. The first run of three nametable reads in a row therefore marks cycle 0 of a line, which is the fetch for the line's third tile.

The block counts detected lines within a frame. A run of idle clocks with no reads marks vertical blanking and ends the frame. When the count of a newly detected line equals a compare value supplied by the CPU-side register logic, the block raises an interrupt request, provided the enable bit is set. The request stays up until it is acknowledged or the enable bit is cleared. A rendering-active hint lets the host force the detector into its idle state.

Top module: `lineIrqSnoop`

## Requirements
- R1: A read counts as a nametable read only when its 14-bit address lies in 0x2000..0x2FFF and its low 10 bits are not in 0x3C0..0x3FF. Any other read, including an attribute read inside that range, breaks a run of nametable reads.
- R2: A line is detected on the third consecutive nametable read. Further nametable reads in the same unbroken run detect nothing more.
- R3: The first line detected while `inFrame` is 0 sets `inFrame` to 1 and loads `lineCount` with 0. Both are visible right after the clock edge that captures the detecting read.
- R4: Each later line detected while `inFrame` is 1 adds one to `lineCount`. The count saturates at 255.
- R5: `irqOut` rises at the clock edge that captures the third-tile nametable read of the line whose new count equals `cmpVal`, and not earlier. A `cmpVal` of 0 never raises it.
- R6: Once high, `irqOut` stays high until `irqAck` is sampled high or `irqEnable` is sampled low. It then reads 0 after that edge.
- R7: After `IDLE_LIMIT` consecutive clocks without a read strobe, `inFrame` clears. The next detected line starts again at count 0.
- R8: While `renderHint` is low, `inFrame` clears, the nametable run is discarded and no line is detected.
- R9: Reset (active-low `rstN`) clears `lineCount`, `inFrame` and `irqOut`.
- R10: A matching line detected while `irqEnable` is low does not raise `irqOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video memory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vidAddr | input | 14 | Video processor address bus |
| rdStrobe | input | 1 | High for one clock per read access, qualifying `vidAddr` |
| renderHint | input | 1 | High while the video processor is rendering |
| cmpVal | input | 8 | Scanline compare value |
| irqEnable | input | 1 | Interrupt enable |
| irqAck | input | 1 | Acknowledge strobe, clears a pending request |
| irqOut | output | 1 | Interrupt request, active high |
| inFrame | output | 1 | High between the first detected line and vertical blanking |
| lineCount | output | 8 | Count of the most recently detected line in the frame |

## Verification
The assertions assume that `cmpVal` does not change between a detecting read and the following edge. They also assume that `rdStrobe` is a single-clock pulse per access, so that one fetch is one read. The stimulus follows both rules. It builds each line from a modelled fetch order: background tile groups of nametable, attribute and two pattern reads, then sprite pattern reads for blanking, then two prefetched tiles and two dummy nametable reads. Each read is one strobe clock followed by one quiet clock, which keeps the gaps inside a frame far below the idle limit. Register writes and the hint only change between fetches.

// File: rtl/scanIrqPkg.sv
package scanIrqPkg;

  localparam int VID_ADDR_W = 14;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic runInc;    // extend the nametable run
    logic runClr;    // discard the nametable run
    logic idleClr;   // a read was seen, restart idle timing
    logic lineZero;  // first line of a frame: load count 0
    logic lineStep;  // later line: advance the count
  } snoopStrobe_t;

  // Nametable fetch: inside 0x2000..0x2FFF, attribute slots excluded.
  function automatic logic isNameFetch(input logic [VID_ADDR_W-1:0] addr);
    return (addr[13:12] == 2'b10) && (addr[9:6] != 4'hF);
  endfunction

endpackage

// File: rtl/scanIrqData.sv
module scanIrqData
  import scanIrqPkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int IDLE_LIMIT = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rdStrobe,
  input  logic [VID_ADDR_W-1:0] vidAddr,
  input  logic [CNT_W-1:0]      cmpVal,
  input  snoopStrobe_t          stb,
  output logic                  ntHit,
  output logic                  runTwo,
  output logic                  idleDone,
  output logic                  stepMatch,
  output logic [CNT_W-1:0]      lineCount
);

  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_LIMIT - 1);
  localparam logic [IDLE_W-1:0] IDLE_TOP  = IDLE_W'(IDLE_LIMIT);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic [1:0]        runLen;
  logic [IDLE_W-1:0] idleCnt;
  logic [CNT_W-1:0]  stepVal;

  assign ntHit    = isNameFetch(vidAddr);
  assign runTwo   = (runLen == 2'd2);
  assign idleDone = !rdStrobe && (idleCnt == IDLE_LAST);
  assign stepVal  = (lineCount == CNT_MAX) ? CNT_MAX : lineCount + 1'b1;
  assign stepMatch = (cmpVal != '0) && (cmpVal == stepVal);

  // Length of the current unbroken nametable run, saturating at 3.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           runLen <= '0;
    else if (stb.runClr)                 runLen <= '0;
    else if (stb.runInc && runLen != 2'd3) runLen <= runLen + 2'd1;
  end

  // Clocks since the last read, saturating at the limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 idleCnt <= '0;
    else if (stb.idleClr)      idleCnt <= '0;
    else if (idleCnt != IDLE_TOP) idleCnt <= idleCnt + 1'b1;
  end

  // Line counter within the frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lineCount <= '0;
    else if (stb.lineZero) lineCount <= '0;
    else if (stb.lineStep) lineCount <= stepVal;
  end

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lineStep && lineCount == CNT_MAX) |=> (lineCount == CNT_MAX));

  // R2
  no_double_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.lineZero || stb.lineStep) |=> !runTwo);

endmodule

// File: rtl/scanIrqCtrl.sv
module scanIrqCtrl
  import scanIrqPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdStrobe,
  input  logic         renderHint,
  input  logic         irqEnable,
  input  logic         irqAck,
  input  logic         ntHit,
  input  logic         runTwo,
  input  logic         idleDone,
  input  logic         stepMatch,
  output snoopStrobe_t stb,
  output logic         inFrame,
  output logic         irqOut
);

  logic lineDet;
  logic setEv;
  logic frameStop;

  assign lineDet   = rdStrobe && renderHint && ntHit && runTwo;
  assign frameStop = !renderHint || idleDone;

  always_comb begin
    stb          = '0;
    stb.idleClr  = rdStrobe;
    stb.runClr   = frameStop || (rdStrobe && !ntHit);
    stb.runInc   = rdStrobe && ntHit && renderHint;
    stb.lineZero = lineDet && !inFrame;
    stb.lineStep = lineDet && inFrame;
  end

  assign setEv = stb.lineStep && stepMatch && irqEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          inFrame <= 1'b0;
    else if (frameStop) inFrame <= 1'b0;
    else if (lineDet)   inFrame <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= setEv || (irqOut && irqEnable && !irqAck);
  end

  // R8
  hint_low_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !renderHint |=> !inFrame);

  // R7
  idle_frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleDone |=> !inFrame);

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !setEv) |=> !irqOut);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |=> !irqOut);

endmodule

// File: rtl/lineIrqSnoop.sv
module lineIrqSnoop
  import scanIrqPkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int IDLE_LIMIT = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [VID_ADDR_W-1:0] vidAddr,
  input  logic                  rdStrobe,
  input  logic                  renderHint,
  input  logic [CNT_W-1:0]      cmpVal,
  input  logic                  irqEnable,
  input  logic                  irqAck,
  output logic                  irqOut,
  output logic                  inFrame,
  output logic [CNT_W-1:0]      lineCount
);

  snoopStrobe_t stb;
  logic ntHit, runTwo, idleDone, stepMatch;

  scanIrqData #(.CNT_W(CNT_W), .IDLE_LIMIT(IDLE_LIMIT)) i_data (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .vidAddr(vidAddr),
    .cmpVal(cmpVal), .stb(stb), .ntHit(ntHit), .runTwo(runTwo),
    .idleDone(idleDone), .stepMatch(stepMatch), .lineCount(lineCount)
  );

  scanIrqCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .renderHint(renderHint),
    .irqEnable(irqEnable), .irqAck(irqAck), .ntHit(ntHit), .runTwo(runTwo),
    .idleDone(idleDone), .stepMatch(stepMatch), .stb(stb),
    .inFrame(inFrame), .irqOut(irqOut)
  );

  // R3
  frame_start_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFrame) |-> (lineCount == '0));

  // R5
  irq_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> (inFrame && lineCount == cmpVal && cmpVal != '0));

endmodule

// File: tb/test_lineIrqSnoop.sv
module test_lineIrqSnoop;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE_LIM   = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] vidAddr = '0;
  logic        rdStrobe = 1'b0;
  logic        renderHint = 1'b1;
  logic [7:0]  cmpVal = '0;
  logic        irqEnable = 1'b0;
  logic        irqAck = 1'b0;
  logic        irqOut, inFrame;
  logic [7:0]  lineCount;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  expIrq  = 1'b0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lineIrqSnoop #(.CNT_W(8), .IDLE_LIMIT(IDLE_LIM)) i_lineIrqSnoop (
    .clk(clk), .rstN(rstN), .vidAddr(vidAddr), .rdStrobe(rdStrobe),
    .renderHint(renderHint), .cmpVal(cmpVal), .irqEnable(irqEnable),
    .irqAck(irqAck), .irqOut(irqOut), .inFrame(inFrame), .lineCount(lineCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One read: strobe for one clock, then one quiet clock.
  task automatic fetch(input logic [13:0] a);
    @(negedge clk); rdStrobe = 1'b1; vidAddr = a;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic tile(input int n);
    fetch(14'h2000 + 14'(n));
    fetch(14'h23C0 + 14'(n % 64));
    fetch(14'h0000 + 14'(n * 16));
    fetch(14'h0008 + 14'(n * 16));
  endtask

  // Prefetch of two tiles plus the two dummy nametable reads.
  task automatic lineTail();
    tile(0); tile(1);
    fetch(14'h2000); fetch(14'h2000);
  endtask

  task automatic idleGap();
    repeat (IDLE_LIM + 4) @(negedge clk);
  endtask

  // Full modelled line; its first read is the third-tile nametable fetch.
  task automatic fullLine(input int k);
    chk("R5 irq before third-tile fetch", irqOut, expIrq);
    if (irqEnable && cmpVal != 0 && k == cmpVal) expIrq = 1'b1;
    fetch(14'h2002);
    chk("R3/R4 lineCount at line start", lineCount, k);
    chk("R3 inFrame at line start", inFrame, 1);
    chk("R5 irq at third-tile fetch", irqOut, expIrq);
    fetch(14'h23C0); fetch(14'h0020); fetch(14'h0028);
    for (int t = 3; t < 34; t++) tile(t);
    for (int s = 0; s < 16; s++) fetch(14'h1000 + 14'(s * 8));
    lineTail();
  endtask

  task automatic pulseAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
    expIrq = 1'b0;
    chk("R6 irq cleared by ack", irqOut, 0);
  endtask

  task automatic testReset();
    repeat (2) @(negedge clk);
    chk("R9 lineCount in reset", lineCount, 0);
    chk("R9 inFrame in reset", inFrame, 0);
    chk("R9 irq in reset", irqOut, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testBasicFrame();
    cmpVal = 8'd5; irqEnable = 1'b1; expIrq = 1'b0;
    lineTail();
    for (int k = 0; k < 8; k++) fullLine(k);
    chk("R6 irq held without ack", irqOut, 1);
    pulseAck();
    idleGap();
    chk("R7 inFrame cleared by idle", inFrame, 0);
    lineTail();
    fullLine(0);
    chk("R7 new frame restarts at 0", lineCount, 0);
    idleGap();
  endtask

  task automatic testCmpZero();
    cmpVal = 8'd0; irqEnable = 1'b1; expIrq = 1'b0;
    lineTail();
    for (int k = 0; k < 4; k++) fullLine(k);
    chk("R5 compare 0 never fires", irqOut, 0);
    idleGap();
  endtask

  task automatic testEnable();
    cmpVal = 8'd2; irqEnable = 1'b0; expIrq = 1'b0;
    lineTail();
    for (int k = 0; k < 4; k++) fullLine(k);
    chk("R10 no irq while disabled", irqOut, 0);
    @(negedge clk); irqEnable = 1'b1; cmpVal = 8'd5;
    fullLine(4); fullLine(5);
    chk("R5 irq after enabling", irqOut, 1);
    @(negedge clk); irqEnable = 1'b0;
    @(negedge clk);
    chk("R6 irq cleared by disable", irqOut, 0);
    expIrq = 1'b0; irqEnable = 1'b1;
    idleGap();
  endtask

  task automatic testRunBreaks();
    cmpVal = 8'd0; expIrq = 1'b0;
    lineTail();
    fullLine(0);
    fetch(14'h2BC5);
    fetch(14'h2004); fetch(14'h2005);
    chk("R1 attribute read breaks run", lineCount, 0);
    fetch(14'h3001);
    fetch(14'h2006); fetch(14'h2007);
    chk("R1 out-of-range read breaks run", lineCount, 0);
    fetch(14'h2008);
    chk("R1 third nametable read detects", lineCount, 1);
    fetch(14'h2009); fetch(14'h200A);
    chk("R2 longer run counts once", lineCount, 1);
    fetch(14'h1FFF);
    fetch(14'h2000); fetch(14'h2001); fetch(14'h2002);
    chk("R2 new run detects again", lineCount, 2);
    idleGap();
  endtask

  task automatic testRenderHint();
    cmpVal = 8'd0; expIrq = 1'b0;
    lineTail();
    fullLine(0); fullLine(1);
    @(negedge clk); renderHint = 1'b0;
    @(negedge clk);
    chk("R8 hint low clears inFrame", inFrame, 0);
    fetch(14'h2000); fetch(14'h2001); fetch(14'h2002);
    chk("R8 no detection while hint low", inFrame, 0);
    chk("R8 count unchanged while hint low", lineCount, 1);
    @(negedge clk); renderHint = 1'b1;
    fetch(14'h2000); fetch(14'h2001);
    chk("R8 run discarded while hint low", inFrame, 0);
    fetch(14'h2002);
    chk("R8 restart after hint at 0", lineCount, 0);
    chk("R3 inFrame after restart", inFrame, 1);
    idleGap();
  endtask

  task automatic testSaturate();
    cmpVal = 8'd0; expIrq = 1'b0;
    fetch(14'h2000); fetch(14'h2000);
    for (int k = 0; k < 260; k++) begin
      fetch(14'h2003); fetch(14'h23C1); fetch(14'h2000); fetch(14'h2001);
    end
    chk("R4 count saturates at 255", lineCount, 255);
    chk("R4 still in frame", inFrame, 1);
    idleGap();
  endtask

  initial begin
    testReset();
    testBasicFrame();
    testCmpZero();
    testEnable();
    testRunBreaks();
    testRenderHint();
    testSaturate();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule